// File: doc/BRIEF.md
# DMA Bus Handshake Controller

This block decides when an external DMA controller may take over the shared address/data bus. Software arms it by issuing an internal enable command, which sets a flag, and disarms it with a separate disable command. The DMA controller asks for the bus by pulling an active-low request low. It keeps the request low for the whole transfer and raises it again when it is done.

The request is passed through a synchronizer before it is evaluated. All grant and release decisions are taken only in cycles that carry a strobe marking the falling edge of the sync clock. While the bus is granted, the active-low acknowledge and the active-low processor-pause output are both low. During that time the processor's bus drivers are released to high impedance, and the bus-fault watchdog is held disabled. The clock generator and the hold-request path are outside this block.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After reset, `dma_ack_n` and `cpu_pause_n` are 1, `dma_en` is 0, `bus_drv_en` is 1 and `wdog_run` is 1.
- R2: A one-cycle pulse on `cmd_enable` sets `dma_en` to 1 from the next clock. A pulse on `cmd_disable` clears it. When both pulse in the same cycle, `dma_en` becomes 0.
- R3: If the synchronized request is low and `dma_en` is 1 in a cycle with `sync_fall` = 1, then `dma_ack_n` is 0 from the next clock.
- R4: While `dma_en` is 0, an idle handshake never grants, whatever `dma_req_n` and `sync_fall` do.
- R5: `dma_ack_n` changes only in the clock that follows a cycle with `sync_fall` = 1. A request change without a strobe leaves it unchanged.
- R6: During a grant, the first `sync_fall` cycle in which the synchronized request is high returns `dma_ack_n` to 1 at the next clock.
- R7: Clearing `dma_en` during a grant does not end that grant. Only the request going high ends it. Once it has ended, a new request is not granted while `dma_en` is 0.
- R8: `cpu_pause_n` is 0 exactly when `dma_ack_n` is 0. In that state `bus_drv_en` (1 = the processor drives the bus) and `wdog_run` (1 = the bus-fault watchdog may count) are both 0. Otherwise both are 1.
- R9: `dma_req_n` passes through SYNC_STAGES (default 2) flip-flops before it is evaluated. A request that goes low only one clock before a strobe cycle is not granted by that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_fall | input | 1 | One-cycle strobe marking a falling sync-clock edge |
| cmd_enable | input | 1 | Internal command pulse that sets the enable flag |
| cmd_disable | input | 1 | Internal command pulse that clears the enable flag |
| dma_req_n | input | 1 | Asynchronous active-low DMA request |
| dma_en | output | 1 | Enable flag state |
| dma_ack_n | output | 1 | Active-low acknowledge to the DMA controller |
| cpu_pause_n | output | 1 | Active-low processor pause |
| bus_drv_en | output | 1 | Processor bus driver enable; 0 releases the bus to high impedance |
| wdog_run | output | 1 | Bus-fault watchdog enable; 0 holds it reset |

## Verification
The handshake is driven with a request held low across several strobes, with a request that changes between strobes, and with a request that falls just one clock before a strobe. These three patterns separate strobe gating from the synchronizer delay. Runs with the flag disabled, and with the flag cleared in the middle of a transfer, show that the flag gates new grants but does not end a grant in progress. A cycle where both commands pulse at once pins down which command wins. The pause, bus-driver and watchdog outputs are compared against the acknowledge in every check.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

  typedef enum logic {
    HS_IDLE  = 1'b0,
    HS_GRANT = 1'b1
  } hs_state_t;

  // Next handshake state: moves only on a sync-clock falling strobe.
  function automatic hs_state_t hs_next(input hs_state_t cur,
                                        input logic      strobe,
                                        input logic      req_n,
                                        input logic      en);
    hs_state_t nxt;
    nxt = cur;
    if (strobe) begin
      case (cur)
        HS_IDLE:  if (!req_n && en) nxt = HS_GRANT;
        HS_GRANT: if (req_n)        nxt = HS_IDLE;
        default:                    nxt = HS_IDLE;
      endcase
    end
    return nxt;
  endfunction

  // Enable flag update: disable has priority over enable.
  function automatic logic en_next(input logic cur, input logic set, input logic clr);
    logic nxt;
    nxt = cur;
    if (set) nxt = 1'b1;
    if (clr) nxt = 1'b0;
    return nxt;
  endfunction

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_async,
  output logic req_n_sync
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= req_n_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign req_n_sync = chain[LAST];
endmodule

// File: rtl/dma_en_flag.sv
module dma_en_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_cmd,
  input  logic clr_cmd,
  output logic en
);
  import dma_hs_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else        en <= en_next(en, set_cmd, clr_cmd);
  end

  p_disable_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> !en);
  p_enable_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cmd && !clr_cmd) |=> en);
endmodule

// File: rtl/dma_grant_fsm.sv
module dma_grant_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic req_n_sync,
  input  logic en,
  output logic granted
);
  import dma_hs_pkg::*;

  hs_state_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= HS_IDLE;
    else        state <= hs_next(state, strobe, req_n_sync, en);
  end

  assign granted = (state == HS_GRANT);

  p_grant_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(granted) |-> ($past(strobe) && $past(en) && !$past(req_n_sync)));
  p_idle_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!granted && !en) |=> !granted);
  p_only_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(granted));
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (granted && strobe && req_n_sync) |=> !granted);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (granted && !req_n_sync) |=> granted);
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_fall,
  input  logic cmd_enable,
  input  logic cmd_disable,
  input  logic dma_req_n,
  output logic dma_en,
  output logic dma_ack_n,
  output logic cpu_pause_n,
  output logic bus_drv_en,
  output logic wdog_run
);
  // Named internal events for the assertions.
  logic req_n_s;
  logic granted;

  dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_n_async (dma_req_n),
    .req_n_sync  (req_n_s)
  );

  dma_en_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_cmd (cmd_enable),
    .clr_cmd (cmd_disable),
    .en      (dma_en)
  );

  dma_grant_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (sync_fall),
    .req_n_sync (req_n_s),
    .en         (dma_en),
    .granted    (granted)
  );

  assign dma_ack_n   = ~granted;
  assign cpu_pause_n = ~granted;
  assign bus_drv_en  = ~granted;
  assign wdog_run    = ~granted;

  p_pause_tracks_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_pause_n == dma_ack_n) && (bus_drv_en == cpu_pause_n) && (wdog_run == cpu_pause_n));
  p_ack_drop_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_ack_n) |-> $past(sync_fall));
endmodule

// File: tb/test_dma_bus_arbiter.sv
module test_dma_bus_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_fall = 1'b0;
  logic cmd_enable = 1'b0;
  logic cmd_disable = 1'b0;
  logic dma_req_n = 1'b1;
  logic dma_en, dma_ack_n, cpu_pause_n, bus_drv_en, wdog_run;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dma_bus_arbiter i_dma_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .sync_fall(sync_fall),
    .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .dma_req_n(dma_req_n), .dma_en(dma_en), .dma_ack_n(dma_ack_n),
    .cpu_pause_n(cpu_pause_n), .bus_drv_en(bus_drv_en), .wdog_run(wdog_run)
  );

  // Expected outputs given whether the bus is granted (R8 restated).
  task automatic check_bus(input logic exp_granted, input string tag);
    logic [3:0] act, exp;
    act = {dma_ack_n, cpu_pause_n, bus_drv_en, wdog_run};
    exp = exp_granted ? 4'b0000 : 4'b1111;
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: ack/pause/drv/wdog act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic check_en(input logic exp, input string tag);
    n_cmp++;
    if (dma_en !== exp) begin
      n_bad++;
      $display("FAIL %s: dma_en act=%b exp=%b", tag, dma_en, exp);
    end
  endtask

  // Each helper leaves the bench at a negedge after the effect is visible.
  task automatic strobe;
    @(negedge clk) sync_fall = 1'b1;
    @(negedge clk) sync_fall = 1'b0;
  endtask

  task automatic cmd(input logic set, input logic clr);
    @(negedge clk) begin cmd_enable = set; cmd_disable = clr; end
    @(negedge clk) begin cmd_enable = 1'b0; cmd_disable = 1'b0; end
  endtask

  task automatic set_req(input logic v);
    @(negedge clk) dma_req_n = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check_bus(1'b0, "R1 reset");
    check_en(1'b0, "R1 reset");
  endtask

  task automatic t_enable_cmds;
    cmd(1'b1, 1'b0); check_en(1'b1, "R2 enable");
    cmd(1'b0, 1'b1); check_en(1'b0, "R2 disable");
    cmd(1'b1, 1'b0);
    cmd(1'b1, 1'b1); check_en(1'b0, "R2 both");
  endtask

  task automatic t_no_grant_disabled;
    set_req(1'b0);
    strobe(); check_bus(1'b0, "R4 disabled strobe1");
    strobe(); check_bus(1'b0, "R4 disabled strobe2");
    set_req(1'b1);
  endtask

  task automatic t_sync_latency;
    cmd(1'b1, 1'b0);
    @(negedge clk) dma_req_n = 1'b0;   // only one flop sees it before strobe
    strobe(); check_bus(1'b0, "R9 too early");
    strobe(); check_bus(1'b1, "R3 grant after sync");
  endtask

  task automatic t_hold_and_release;
    repeat (4) @(negedge clk);
    check_bus(1'b1, "R5 no strobe hold");
    strobe(); check_bus(1'b1, "R6 req still low");
    set_req(1'b1);
    check_bus(1'b1, "R5 release waits for strobe");
    strobe(); check_bus(1'b0, "R6 release");
  endtask

  task automatic t_grant_wait_strobe;
    set_req(1'b0);
    check_bus(1'b0, "R5 grant waits for strobe");
    strobe(); check_bus(1'b1, "R3 grant");
  endtask

  task automatic t_disable_mid;
    cmd(1'b0, 1'b1);
    check_en(1'b0, "R7 flag cleared");
    strobe(); check_bus(1'b1, "R7 transfer continues");
    set_req(1'b1);
    strobe(); check_bus(1'b0, "R7 transfer ends");
    set_req(1'b0);
    strobe(); check_bus(1'b0, "R7 no regrant");
    set_req(1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_cmds();
    t_no_grant_disabled();
    t_sync_latency();
    t_hold_and_release();
    t_grant_wait_strobe();
    t_disable_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: act=timeout exp=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule